// File: doc/BRIEF.md
# Three-Point Calibration Corrector

This block turns raw 24-bit signed conversion codes into calibrated 16-bit signed results. Each channel has three stored reference readings: the code seen with the input at zero, the code seen at positive full scale and the code seen at negative full scale. The zero reading is subtracted from every sample. The difference is then multiplied by one of two gain slopes, and the slope is picked by the sign of that difference. The product is scaled down to 16 bits and clamped to the signed range.

Firmware records the three readings through a capture port. It tags each write with the channel and with which reference point the code belongs to. A separate calibrate command then derives both slopes for one channel. Two restoring dividers run side by side and take a fixed number of cycles. While they run, the sample path keeps working with the slopes it already holds. A channel whose reference span is empty or inverted gets a zero slope on that side, and an error flag is raised for that side.

Top module: `cal_corrector`

## Requirements
- R1: A capture write with `cap_valid` high stores `cap_code` for channel `cap_chan` as the zero reading when `cap_point` is 0, as the positive full-scale reading when it is 1, or as the negative full-scale reading when it is 2. Value 3 stores nothing.
- R2: When `cal_go` is high and `busy` is low, slope computation starts for channel `cal_chan`. `busy` is high in the next cycle and stays high for exactly 25 cycles. Captures and further `cal_go` pulses are ignored while `busy` is high.
- R3: A sample given with `in_valid` high appears one cycle later with `out_valid` high. The result is out = ((x − zero) · slope) >>> 30, with arithmetic (floor) shift. The positive slope is used when x − zero ≥ 0, and the negative slope otherwise.
- R4: Slopes are unsigned fixed point with 22 fraction bits. Each is floor(2^45 / span), where span is (positive − zero) for the positive slope and (zero − negative) for the negative slope.
- R5: When span is positive but floor(2^45/span) exceeds 2^24 − 1 (span ≤ 2^21), the slope saturates to 2^24 − 1.
- R6: When span ≤ 0, that slope is set to 0 and the channel's error bit for that side (`err_pos` or `err_neg`) is set. A later calibration of that channel with a positive span clears the bit. Error bits change only at the end of a calibration.
- R7: The output saturates to the range −32768 … +32767.
- R8: After reset every channel has zero offset and unity slopes (2^22), so out = x >>> 8. Also after reset, `out_valid`, `busy` and all error bits are low.
- R9: Calibrating one channel leaves the readings and slopes of the other channels unchanged.
- R10: When `in_valid` is low, `out_valid` is low in the next cycle and `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_valid | input | 1 | Capture strobe for a reference reading |
| cap_point | input | 2 | Reference point: 0 zero, 1 positive full scale, 2 negative full scale, 3 none |
| cap_chan | input | 2 | Channel of the capture |
| cap_code | input | 24 | Reference reading, signed |
| cal_go | input | 1 | Start slope computation |
| cal_chan | input | 2 | Channel to calibrate |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 2 | Channel of the sample |
| in_code | input | 24 | Raw signed sample |
| out_valid | output | 1 | Corrected sample valid |
| out_data | output | 16 | Corrected signed result |
| busy | output | 1 | Slope computation in progress |
| err_pos | output | 4 | Per-channel positive-span error |
| err_neg | output | 4 | Per-channel negative-span error |

## Verification
The hardest states to reach from the ports are the clamp regions of the slope: a span small enough to force slope saturation, and a span that is empty or inverted. Both only appear after a full capture-and-divide sequence. The bench therefore writes reference readings chosen so that each span lands on an exact power of two, inside the saturation window, at zero, or below zero, and then runs the divider. It also issues captures and a second calibrate command during the busy window. Afterwards it recalibrates and checks that the outputs show none of those ignored writes took effect.

// File: rtl/cal_pkg.sv
package cal_pkg;

    // Reference point selector used on the capture port
    typedef enum logic [1:0] {
        PT_ZERO = 2'd0,
        PT_POS  = 2'd1,
        PT_NEG  = 2'd2,
        PT_NONE = 2'd3
    } cal_point_e;

endpackage

// File: rtl/cal_divider.sv
// Restoring divider: quotient = floor(2^NUM_EXP / den), QW bits, one bit per cycle.
module cal_divider #(
    parameter int DEN_W   = 25,
    parameter int QW      = 24,
    parameter int NUM_EXP = 45
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [DEN_W-1:0] den,
    output logic                    busy,
    output logic                    done,
    output logic [QW-1:0]           quo,
    output logic                    err
);
    localparam int RW      = DEN_W + 1;
    localparam int SAT_EXP = NUM_EXP - QW;
    localparam int CW      = $clog2(QW + 1);
    localparam logic [RW-1:0] REM_INIT = RW'(1) << SAT_EXP;
    localparam logic signed [DEN_W-1:0] SAT_LIM = DEN_W'(1) << SAT_EXP;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        logic          sat;
        logic [CW-1:0] cnt;
        logic [RW-1:0] rem;
        logic [RW-1:0] dv;
        logic [QW-1:0] quo;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [RW-1:0] rem_sh;
    logic          qbit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem_sh    = {st_q.rem[RW-2:0], 1'b0};
        qbit      = 1'b0;
        if (st_q.busy) begin
            if (rem_sh >= st_q.dv) begin
                st_d.rem = rem_sh - st_q.dv;
                qbit     = 1'b1;
            end else begin
                st_d.rem = rem_sh;
            end
            st_d.quo = {st_q.quo[QW-2:0], qbit};
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (st_q.err) begin
                    st_d.quo = '0;
                end else if (st_q.sat) begin
                    st_d.quo = '1;
                end
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(QW);
            st_d.rem  = REM_INIT;
            st_d.quo  = '0;
            st_d.err  = (den <= 0);
            st_d.sat  = (den > 0) && (den <= SAT_LIM);
            st_d.dv   = {1'b0, den};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
    assign quo  = st_q.quo;
    assign err  = st_q.err;

endmodule

// File: rtl/cal_scaler.sv
// Offset removal, sign-selected slope multiply, down-scale and clamp.
module cal_scaler #(
    parameter int IN_W  = 24,
    parameter int QW    = 24,
    parameter int FRAC  = 22,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  code,
    input  logic [IN_W-1:0]  zero,
    input  logic [QW-1:0]    sl_pos,
    input  logic [QW-1:0]    sl_neg,
    output logic [OUT_W-1:0] res
);
    localparam int DW = IN_W + 1;
    localparam int PW = DW + QW + 1;
    localparam int SH = FRAC + (IN_W - OUT_W);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) << (OUT_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) << (OUT_W - 1));

    logic signed [DW-1:0] diff;
    logic        [QW-1:0] sl;
    logic signed [PW-1:0] diff_x;
    logic signed [PW-1:0] sl_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shv;

    always_comb begin
        diff   = $signed({code[IN_W-1], code}) - $signed({zero[IN_W-1], zero});
        sl     = diff[DW-1] ? sl_neg : sl_pos;
        diff_x = diff;
        sl_x   = $signed({{(PW-QW){1'b0}}, sl});
        prod   = diff_x * sl_x;
        shv    = prod >>> SH;
        if (shv > MAXV) begin
            res = MAXV[OUT_W-1:0];
        end else if (shv < MINV) begin
            res = MINV[OUT_W-1:0];
        end else begin
            res = shv[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
    parameter int NCH   = 4,
    parameter int IN_W  = 24,
    parameter int OUT_W = 16,
    parameter int FRAC  = 22,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic [1:0]       cap_point,
    input  logic [CHW-1:0]   cap_chan,
    input  logic [IN_W-1:0]  cap_code,
    input  logic             cal_go,
    input  logic [CHW-1:0]   cal_chan,
    input  logic             in_valid,
    input  logic [CHW-1:0]   in_chan,
    input  logic [IN_W-1:0]  in_code,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             busy,
    output logic [NCH-1:0]   err_pos,
    output logic [NCH-1:0]   err_neg
);
    import cal_pkg::*;

    localparam int QW      = FRAC + 2;
    localparam int DEN_W   = IN_W + 1;
    localparam int NUM_EXP = IN_W - 1 + FRAC;
    localparam logic [QW-1:0] UNITY = QW'(1) << FRAC;

    typedef struct packed {
        logic [NCH-1:0][IN_W-1:0] zero;
        logic [NCH-1:0][IN_W-1:0] pos;
        logic [NCH-1:0][IN_W-1:0] neg;
        logic [NCH-1:0][QW-1:0]   sl_pos;
        logic [NCH-1:0][QW-1:0]   sl_neg;
        logic [NCH-1:0]           err_pos;
        logic [NCH-1:0]           err_neg;
        logic [CHW-1:0]           cal_ch;
        logic                     out_valid;
        logic [OUT_W-1:0]         out_data;
    } st_t;

    st_t st_d, st_q;

    logic                    go_ok;
    logic signed [DEN_W-1:0] span_pos, span_neg;
    logic                    dp_busy, dp_done, dp_err;
    logic                    dn_busy, dn_done, dn_err;
    logic [QW-1:0]           dp_quo, dn_quo;
    logic [OUT_W-1:0]        scaled;

    assign busy  = dp_busy | dn_busy | dp_done | dn_done;
    assign go_ok = cal_go && !busy;

    // Spans for the channel being calibrated, from the stored readings
    always_comb begin
        span_pos = $signed({st_q.pos[cal_chan][IN_W-1], st_q.pos[cal_chan]})
                 - $signed({st_q.zero[cal_chan][IN_W-1], st_q.zero[cal_chan]});
        span_neg = $signed({st_q.zero[cal_chan][IN_W-1], st_q.zero[cal_chan]})
                 - $signed({st_q.neg[cal_chan][IN_W-1], st_q.neg[cal_chan]});
    end

    cal_divider #(.DEN_W(DEN_W), .QW(QW), .NUM_EXP(NUM_EXP)) u_div_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_ok),
        .den   (span_pos),
        .busy  (dp_busy),
        .done  (dp_done),
        .quo   (dp_quo),
        .err   (dp_err)
    );

    cal_divider #(.DEN_W(DEN_W), .QW(QW), .NUM_EXP(NUM_EXP)) u_div_neg (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_ok),
        .den   (span_neg),
        .busy  (dn_busy),
        .done  (dn_done),
        .quo   (dn_quo),
        .err   (dn_err)
    );

    cal_scaler #(.IN_W(IN_W), .QW(QW), .FRAC(FRAC), .OUT_W(OUT_W)) u_scaler (
        .code   (in_code),
        .zero   (st_q.zero[in_chan]),
        .sl_pos (st_q.sl_pos[in_chan]),
        .sl_neg (st_q.sl_neg[in_chan]),
        .res    (scaled)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = in_valid;
        if (in_valid) begin
            st_d.out_data = scaled;
        end
        if (cap_valid && !busy) begin
            case (cal_point_e'(cap_point))
                PT_ZERO: st_d.zero[cap_chan] = cap_code;
                PT_POS:  st_d.pos[cap_chan]  = cap_code;
                PT_NEG:  st_d.neg[cap_chan]  = cap_code;
                default: ;
            endcase
        end
        if (go_ok) begin
            st_d.cal_ch = cal_chan;
        end
        if (dp_done) begin
            st_d.sl_pos[st_q.cal_ch]  = dp_quo;
            st_d.err_pos[st_q.cal_ch] = dp_err;
        end
        if (dn_done) begin
            st_d.sl_neg[st_q.cal_ch]  = dn_quo;
            st_d.err_neg[st_q.cal_ch] = dn_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                st_q.sl_pos[i] <= UNITY;
                st_q.sl_neg[i] <= UNITY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign err_pos   = st_q.err_pos;
    assign err_neg   = st_q.err_neg;

endmodule

// File: rtl/cal_corrector_chk.sv
module cal_corrector_chk #(
    parameter int NCH   = 4,
    parameter int OUT_W = 16,
    parameter int FRAC  = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_go,
    input logic             busy,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic [NCH-1:0]   err_pos,
    input logic [NCH-1:0]   err_neg
);
    localparam int BUSY_LEN = FRAC + 3;

    logic [7:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (busy) begin
            bcnt <= bcnt + 8'd1;
        end else begin
            bcnt <= '0;
        end
    end

    assert_busy_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_go && !busy) |=> busy);

    assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == 8'(BUSY_LEN)));

    assert_out_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    assert_errpos_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_pos) |-> $past(busy));

    assert_errneg_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_neg) |-> $past(busy));

endmodule

bind cal_corrector cal_corrector_chk #(.NCH(NCH), .OUT_W(OUT_W), .FRAC(FRAC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_go    (cal_go),
    .busy      (busy),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .err_pos   (err_pos),
    .err_neg   (err_neg)
);

// File: tb/tb_cal_corrector.sv
module tb_cal_corrector;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic signed [23:0] code;
        logic signed [15:0] exp;
    } vec_t;

    // Channel 1 calibrated with zero=1000, pos span 2^22 (slope 2.0), neg span 2^23 (slope 1.0)
    localparam vec_t VECS [NV] = '{
        '{24'sd1000,     16'sd0},
        '{24'sd5096,     16'sd32},
        '{-24'sd3096,    -16'sd16},
        '{24'sd4195304,  16'sd32767},
        '{-24'sd8387608, -16'sd32768},
        '{24'sd1001,     16'sd0},
        '{24'sd999,      -16'sd1},
        '{24'sd26600,    16'sd200},
        '{-24'sd24600,   -16'sd100},
        '{24'sd8388607,  16'sd32767},
        '{-24'sd8388608, -16'sd32768},
        '{24'sd2098152,  16'sd16384}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [1:0]  cap_point = 2'd0;
    logic [1:0]  cap_chan = 2'd0;
    logic [23:0] cap_code = '0;
    logic        cal_go = 1'b0;
    logic [1:0]  cal_chan = 2'd0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_chan = 2'd0;
    logic [23:0] in_code = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        busy;
    logic [3:0]  err_pos, err_neg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_corrector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_point (cap_point),
        .cap_chan  (cap_chan),
        .cap_code  (cap_code),
        .cal_go    (cal_go),
        .cal_chan  (cal_chan),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_code   (in_code),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (busy),
        .err_pos   (err_pos),
        .err_neg   (err_neg)
    );

    function automatic longint slope_of(input longint span);
        longint q;
        if (span <= 0) return 0;
        q = (longint'(1) << 45) / span;
        if (q > 64'd16777215) q = 16777215;
        return q;
    endfunction

    function automatic int model(input longint x, input longint z, input longint sp, input longint sn);
        longint d, p, r;
        d = x - z;
        p = d * ((d >= 0) ? sp : sn);
        r = p >>> 30;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int ch, input logic signed [23:0] code,
                          input int exp, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = 2'(ch);
        in_code  = code;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, longint'(out_valid), 1);
        check(req, longint'($signed(out_data)), exp);
    endtask

    task automatic capture(input int ch, input int pt, input logic signed [23:0] code);
        @(negedge clk);
        cap_valid = 1'b1;
        cap_chan  = 2'(ch);
        cap_point = 2'(pt);
        cap_code  = code;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic calibrate(input int ch, output int cycles);
        @(negedge clk);
        cal_go   = 1'b1;
        cal_chan = 2'(ch);
        @(negedge clk);
        cal_go = 1'b0;
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 out_valid reset", longint'(out_valid), 0);
        check("R8 busy reset", longint'(busy), 0);
        check("R8 err reset", longint'({err_pos, err_neg}), 0);
        rst_n = 1'b1;
        // R8: uncalibrated pass-through with truncation
        sample(0, 24'sh123456, 4660, "R8 pass");
        sample(0, -24'sd1, -1, "R8 pass -1");
        sample(0, -24'sd1280, -5, "R8 pass neg");
        // R1/R4: calibrate channel 1
        capture(1, 0, 24'sd1000);
        capture(1, 1, 24'sd4195304);
        capture(1, 2, -24'sd8387608);
        calibrate(1, cyc);
        check("R2 busy cycles", cyc, 25);
        check("R6 no error ch1", longint'({err_pos[1], err_neg[1]}), 0);
        // R3/R4/R7: table walk
        for (int i = 0; i < NV; i++) begin
            sample(1, VECS[i].code, int'(VECS[i].exp), "R3 R7 table");
        end
        // R10: output holds when idle
        sample(1, 24'sd5096, 32, "R3 before hold");
        @(negedge clk);
        check("R10 valid low", longint'(out_valid), 0);
        check("R10 data held", longint'($signed(out_data)), 32);
        // R9: channel 0 unaffected
        sample(0, 24'sh123456, 4660, "R9 ch0 unchanged");
        // R1: point 3 stores nothing
        capture(1, 3, 24'sd0);
        calibrate(1, cyc);
        sample(1, 24'sd1000, 0, "R1 point3 ignored");
        sample(1, 24'sd5096, 32, "R1 point3 ignored pos");
        // R2: captures and go ignored while busy
        @(negedge clk);
        cal_go = 1'b1; cal_chan = 2'd1;
        @(negedge clk);
        cal_go = 1'b0;
        @(negedge clk);
        cap_valid = 1'b1; cap_chan = 2'd1; cap_point = 2'd0; cap_code = 24'sd0;
        cal_go = 1'b1; cal_chan = 2'd2;
        @(negedge clk);
        cap_valid = 1'b0; cal_go = 1'b0;
        while (busy) @(negedge clk);
        check("R2 go ignored ch2 err", longint'({err_pos[2], err_neg[2]}), 0);
        calibrate(1, cyc);
        sample(1, 24'sd1000, 0, "R2 capture ignored");
        sample(2, 24'sd4096, 16, "R2 ch2 still unity");
        // R5: slope saturation on channel 2, plus non-exact negative slope (R4)
        capture(2, 0, 24'sd0);
        capture(2, 1, 24'sd1048576);
        capture(2, 2, -24'sd3145728);
        calibrate(2, cyc);
        sample(2, 24'sd4096, model(4096, 0, slope_of(1048576), slope_of(3145728)), "R5 sat slope");
        sample(2, -24'sd1048576, model(-1048576, 0, slope_of(1048576), slope_of(3145728)), "R4 neg slope");
        // R6: empty span on channel 3
        capture(3, 0, 24'sd500);
        capture(3, 1, 24'sd500);
        capture(3, 2, 24'sd400);
        calibrate(3, cyc);
        check("R6 err_pos set", longint'(err_pos[3]), 1);
        check("R6 err_neg clear", longint'(err_neg[3]), 0);
        sample(3, 24'sd600, 0, "R6 zero slope");
        sample(3, 24'sd499, -1, "R5 sat neg slope");
        // R6: inverted span keeps error
        capture(3, 1, 24'sd490);
        calibrate(3, cyc);
        check("R6 inverted span err", longint'(err_pos[3]), 1);
        // R6: valid span clears error
        capture(3, 1, 24'sd4194804);
        calibrate(3, cyc);
        check("R6 err cleared", longint'(err_pos[3]), 0);
        sample(3, 24'sd4596, 32, "R6 recovered");
        // R9: channel 1 still holds its calibration
        sample(1, 24'sd26600, 200, "R9 ch1 kept");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule